// File: doc/BRIEF.md
# Double-Chain Source Route Generator

This block runs at the packet source of a 7x7 on-chip network in which every node sits on two chains. The red chain visits the nodes row by row as a snake. The blue chain visits them column by column as a snake. A pulse on `start_i` captures a source and a destination coordinate. The block then works out which route costs least when the network carries no other traffic. It emits that route as a stream of 2-bit per-hop direction codes, one code per cycle, and ends the stream with an arrival flag. The caller packs the stream into the packet header.

A packet can take one of three routes:

- It can stay on the blue chain for the whole trip.
- It can stay on the red chain for the whole trip.
- It can ride the blue chain to a turn node and then ride the red chain to the destination.

A turn is only allowed in the blue-to-red direction, because that ordering keeps the network free of deadlock. A hop along a chain costs one unit. A turn adds a fixed penalty of five hop-equivalents, which comes from a turn delay of three cycles and a link delay of about three quarters of a cycle. The block scans every node as a candidate turn node, one node per cycle. It then compares the three route costs and streams the winning route.

Top module: `dc_route_gen`

## Requirements
- R1: After reset, and whenever the block is not busy, `busy_o`, `hop_valid_o` and `done_o` are low. After reset, `path_o` is 0.
- R2: The red index of node (x,y) is y*7+x when y is even and y*7+6-x when y is odd. The blue index is x*7+y when x is even and x*7+6-y when x is odd. The hop count on a chain is the absolute difference of the two chain indices.
- R3: The blue-straight route (`path_o`=0) wins when its hop count is no larger than the red hop count and no larger than the best turn cost. Such a route emits only blue codes. Because the turn penalty is five, a chain hop count of five or less always beats the turning route.
- R4: The red-straight route (`path_o`=1) wins when it beats the blue hop count strictly and is no larger than the best turn cost. Such a route emits only red codes.
- R5: The turning route (`path_o`=2) wins only when it is strictly cheaper than both straight routes. Its cost is the blue hops to the turn node plus the red hops from the turn node plus 5. The turn node is the node with the lowest cost. Among equal costs, the node with the lowest blue index is chosen. The route emits the blue hops first and then the red hops.
- R6: A blue code never follows a red code within one route.
- R7: The direction codes are 00 for red increasing, 01 for red decreasing, 10 for blue increasing and 11 for blue decreasing.
- R8: After the last hop code, exactly one `done_o` beat marks arrival, with `hop_valid_o` low. When source and destination are the same node, the route has no hop codes and only the arrival beat appears.
- R9: `start_i` is ignored while `busy_o` is high, so the running route is not disturbed.
- R10: `busy_o` rises in the cycle after an accepted start. Hop codes appear on consecutive cycles and are followed directly by `done_o`. `busy_o` stays high until the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a route for the coordinates given (taken only when idle) |
| src_x_i | input | 3 | Source column |
| src_y_i | input | 3 | Source row |
| dst_x_i | input | 3 | Destination column |
| dst_y_i | input | 3 | Destination row |
| busy_o | output | 1 | A route is being computed or emitted |
| hop_valid_o | output | 1 | `hop_dir_o` carries one hop code this cycle |
| hop_dir_o | output | 2 | Per-hop direction code |
| done_o | output | 1 | Arrival flag beat that ends the route |
| path_o | output | 2 | Chosen route: 0 blue, 1 red, 2 turn (held until the next route) |

## Verification
The bench applies several kinds of source and destination pairs, and each kind separates one part of the decision.

- A pair with the same source and destination checks the arrival-only stream.
- Pairs that are row or column neighbours separate the two snake orderings. A column neighbour is one blue hop away, while a row neighbour can be far away on the blue chain.
- Opposite corners force the turning route, and the expected turn node and segment lengths test the cost comparison.
- A full sweep from four sources to every destination crosses the five-hop threshold on both chains and hits cost ties between the routes.
- A second start raised mid-route checks that the running stream is left unchanged.

// File: rtl/dc_route_pkg.sv
package dc_route_pkg;

  typedef enum logic [1:0] {
    DIR_RED_INC = 2'b00,
    DIR_RED_DEC = 2'b01,
    DIR_BLU_INC = 2'b10,
    DIR_BLU_DEC = 2'b11
  } hop_dir_e;

  typedef enum logic [1:0] {
    PATH_BLUE = 2'd0,
    PATH_RED  = 2'd1,
    PATH_TURN = 2'd2
  } path_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DECIDE,
    ST_EMIT
  } gen_state_e;

endpackage

// File: rtl/dc_chain_index.sv
module dc_chain_index #(
  parameter int DIM = 7,
  parameter int CW  = 3,
  parameter int IW  = 6
) (
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  output logic [IW-1:0] red_o,
  output logic [IW-1:0] blue_o
);
  localparam logic [IW-1:0] DIM_W  = IW'(DIM);
  localparam logic [IW-1:0] LAST_W = IW'(DIM - 1);

  // row-wise snake for red, column-wise snake for blue
  always_comb begin
    red_o  = IW'(y_i) * DIM_W + (y_i[0] ? (LAST_W - IW'(x_i)) : IW'(x_i));
    blue_o = IW'(x_i) * DIM_W + (x_i[0] ? (LAST_W - IW'(y_i)) : IW'(y_i));
  end

endmodule

// File: rtl/dc_turn_scan.sv
module dc_turn_scan #(
  parameter int DIM = 7,
  parameter int CW  = 3,
  parameter int IW  = 6,
  parameter int SW  = 8,
  parameter int PEN = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic [IW-1:0] src_blue_i,
  input  logic [IW-1:0] dst_red_i,
  output logic          last_o,
  output logic [SW-1:0] best_cost_o,
  output logic [IW-1:0] best_blue_o,
  output logic [IW-1:0] best_red_o
);
  localparam logic [CW-1:0] LAST_C = CW'(DIM - 1);

  logic [CW-1:0] col_q, pos_q, cand_y;
  logic [IW-1:0] cand_blue, cand_red, cand_blue_chk;
  logic [IW-1:0] b_hops, r_hops;
  logic [SW-1:0] cand_cost;

  // candidates walk in blue-chain order
  assign cand_y = col_q[0] ? (LAST_C - pos_q) : pos_q;

  dc_chain_index #(.DIM(DIM), .CW(CW), .IW(IW)) u_cand_idx (
    .x_i   (col_q),
    .y_i   (cand_y),
    .red_o (cand_red),
    .blue_o(cand_blue_chk)
  );

  assign cand_blue = cand_blue_chk;

  always_comb begin
    b_hops    = (src_blue_i > cand_blue) ? (src_blue_i - cand_blue) : (cand_blue - src_blue_i);
    r_hops    = (dst_red_i > cand_red) ? (dst_red_i - cand_red) : (cand_red - dst_red_i);
    cand_cost = SW'(b_hops) + SW'(r_hops) + SW'(PEN);
  end

  assign last_o = (col_q == LAST_C) && (pos_q == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q       <= '0;
      pos_q       <= '0;
      best_cost_o <= '1;
      best_blue_o <= '0;
      best_red_o  <= '0;
    end else if (clear_i) begin
      col_q       <= '0;
      pos_q       <= '0;
      best_cost_o <= '1;
      best_blue_o <= '0;
      best_red_o  <= '0;
    end else if (en_i) begin
      if (pos_q == LAST_C) begin
        pos_q <= '0;
        col_q <= col_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
      // strict compare keeps the lowest blue index on ties
      if (cand_cost < best_cost_o) begin
        best_cost_o <= cand_cost;
        best_blue_o <= cand_blue;
        best_red_o  <= cand_red;
      end
    end
  end

endmodule

// File: rtl/dc_hop_emit.sv
module dc_hop_emit #(
  parameter int IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [IW-1:0] n1_i,
  input  logic [1:0]    d1_i,
  input  logic [IW-1:0] n2_i,
  input  logic [1:0]    d2_i,
  output logic          hop_valid_o,
  output logic [1:0]    hop_dir_o,
  output logic          done_o
);
  logic          active_q;
  logic [IW-1:0] rem1_q, rem2_q;
  logic [1:0]    d1_q, d2_q;
  logic          seg1, seg2;

  assign seg1 = rem1_q != '0;
  assign seg2 = rem2_q != '0;

  always_comb begin
    hop_valid_o = active_q && (seg1 || seg2);
    hop_dir_o   = seg1 ? d1_q : d2_q;
    done_o      = active_q && !seg1 && !seg2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rem1_q   <= '0;
      rem2_q   <= '0;
      d1_q     <= '0;
      d2_q     <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      rem1_q   <= n1_i;
      rem2_q   <= n2_i;
      d1_q     <= d1_i;
      d2_q     <= d2_i;
    end else if (active_q) begin
      if (seg1)      rem1_q <= rem1_q - 1'b1;
      else if (seg2) rem2_q <= rem2_q - 1'b1;
      else           active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dc_route_gen.sv
module dc_route_gen
  import dc_route_pkg::*;
#(
  parameter int DIM = 7,
  parameter int PEN = 5,
  localparam int CW = $clog2(DIM),
  localparam int IW = $clog2(DIM * DIM),
  localparam int SW = IW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] src_x_i,
  input  logic [CW-1:0] src_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  output logic          busy_o,
  output logic          hop_valid_o,
  output logic [1:0]    hop_dir_o,
  output logic          done_o,
  output logic [1:0]    path_o
);
  gen_state_e    state_q;
  logic [CW-1:0] ex_q [2];
  logic [CW-1:0] ey_q [2];
  logic [IW-1:0] er [2];
  logic [IW-1:0] eb [2];

  logic          accept, scan_last, emit_done, load;
  logic [SW-1:0] best_cost;
  logic [IW-1:0] best_blue, best_red;
  logic [IW-1:0] hb, hr, n1, n2;
  logic [1:0]    d1, d2, path_d;
  path_e         path_q;

  assign accept = (state_q == ST_IDLE) && start_i;

  // endpoint 0 is the source, 1 the destination
  for (genvar g = 0; g < 2; g++) begin : g_ep
    dc_chain_index #(.DIM(DIM), .CW(CW), .IW(IW)) u_idx (
      .x_i   (ex_q[g]),
      .y_i   (ey_q[g]),
      .red_o (er[g]),
      .blue_o(eb[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_q[0] <= '0; ey_q[0] <= '0;
      ex_q[1] <= '0; ey_q[1] <= '0;
    end else if (accept) begin
      ex_q[0] <= src_x_i; ey_q[0] <= src_y_i;
      ex_q[1] <= dst_x_i; ey_q[1] <= dst_y_i;
    end
  end

  dc_turn_scan #(.DIM(DIM), .CW(CW), .IW(IW), .SW(SW), .PEN(PEN)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .en_i       (state_q == ST_SCAN),
    .src_blue_i (eb[0]),
    .dst_red_i  (er[1]),
    .last_o     (scan_last),
    .best_cost_o(best_cost),
    .best_blue_o(best_blue),
    .best_red_o (best_red)
  );

  always_comb begin
    hb = (eb[0] > eb[1]) ? (eb[0] - eb[1]) : (eb[1] - eb[0]);
    hr = (er[0] > er[1]) ? (er[0] - er[1]) : (er[1] - er[0]);
    if ((hb <= hr) && (SW'(hb) <= best_cost)) begin
      path_d = PATH_BLUE;
      n1     = hb;
      d1     = (eb[0] < eb[1]) ? DIR_BLU_INC : DIR_BLU_DEC;
      n2     = '0;
      d2     = DIR_RED_INC;
    end else if (SW'(hr) <= best_cost) begin
      path_d = PATH_RED;
      n1     = hr;
      d1     = (er[0] < er[1]) ? DIR_RED_INC : DIR_RED_DEC;
      n2     = '0;
      d2     = DIR_RED_INC;
    end else begin
      // blue leg first, red leg second: the only legal turn
      path_d = PATH_TURN;
      n1     = (eb[0] > best_blue) ? (eb[0] - best_blue) : (best_blue - eb[0]);
      d1     = (eb[0] < best_blue) ? DIR_BLU_INC : DIR_BLU_DEC;
      n2     = (best_red > er[1]) ? (best_red - er[1]) : (er[1] - best_red);
      d2     = (best_red < er[1]) ? DIR_RED_INC : DIR_RED_DEC;
    end
  end

  assign load = (state_q == ST_DECIDE);

  dc_hop_emit #(.IW(IW)) u_emit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .n1_i       (n1),
    .d1_i       (d1),
    .n2_i       (n2),
    .d2_i       (d2),
    .hop_valid_o(hop_valid_o),
    .hop_dir_o  (hop_dir_o),
    .done_o     (emit_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      path_q  <= PATH_BLUE;
    end else begin
      case (state_q)
        ST_IDLE:   if (start_i) state_q <= ST_SCAN;
        ST_SCAN:   if (scan_last) state_q <= ST_DECIDE;
        ST_DECIDE: begin
          state_q <= ST_EMIT;
          path_q  <= path_e'(path_d);
        end
        ST_EMIT:   if (emit_done) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;
  assign done_o = (state_q == ST_EMIT) && emit_done;
  assign path_o = path_q;

endmodule

// File: rtl/dc_route_gen_chk.sv
module dc_route_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       hop_valid_o,
  input logic [1:0] hop_dir_o,
  input logic       done_o,
  input logic [1:0] path_o
);
  logic seen_red, seen_blue;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_red  <= 1'b0;
      seen_blue <= 1'b0;
    end else if (done_o) begin
      seen_red  <= 1'b0;
      seen_blue <= 1'b0;
    end else if (hop_valid_o) begin
      if (hop_dir_o[1]) seen_blue <= 1'b1;
      else              seen_red  <= 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!hop_valid_o && !done_o));

  a_r3_blue_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && path_o == 2'd0) |-> !seen_red);

  a_r4_red_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && path_o == 2'd1) |-> !seen_blue);

  a_r5_turn_both_legs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && path_o == 2'd2) |-> (seen_red && seen_blue));

  a_r6_no_red_to_blue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hop_valid_o && seen_red) |-> !hop_dir_o[1]);

  a_r8_done_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !hop_valid_o);

  a_r10_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_valid_o |=> (hop_valid_o || done_o));

  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  a_r10_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

endmodule

bind dc_route_gen dc_route_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .hop_valid_o(hop_valid_o),
  .hop_dir_o  (hop_dir_o),
  .done_o     (done_o),
  .path_o     (path_o)
);

// File: tb/sim_dc_route_gen.sv
`timescale 1ns/1ps
module sim_dc_route_gen;
  localparam int D = 7;
  localparam int ARRIVE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] sx = '0, sy = '0, dx = '0, dy = '0;
  logic       busy, hop_valid, done;
  logic [1:0] hop_dir, path;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q [$];
  int path_q [$];

  always #4 clk = ~clk;

  dc_route_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_x_i(sx), .src_y_i(sy), .dst_x_i(dx), .dst_y_i(dy),
    .busy_o(busy), .hop_valid_o(hop_valid), .hop_dir_o(hop_dir),
    .done_o(done), .path_o(path)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int red_ix(int x, int y);
    return y * D + ((y % 2) ? (D - 1 - x) : x);
  endfunction
  function automatic int blue_ix(int x, int y);
    return x * D + ((x % 2) ? (D - 1 - y) : y);
  endfunction
  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  // reference model: pushes expected codes and path
  task automatic expect_route(int a, int b, int c, int e);
    int sb, sr, db, dr, hb, hr, tc, tb, tr;
    sb = blue_ix(a, b); sr = red_ix(a, b);
    db = blue_ix(c, e); dr = red_ix(c, e);
    hb = iabs(sb - db); hr = iabs(sr - dr);
    tc = 1 << 20; tb = 0; tr = 0;
    for (int k = 0; k < D * D; k++) begin
      int x, y, cst;
      x = k / D;
      y = (x % 2) ? (D - 1 - k % D) : (k % D);
      cst = iabs(sb - k) + iabs(red_ix(x, y) - dr) + 5;
      if (cst < tc) begin tc = cst; tb = k; tr = red_ix(x, y); end
    end
    if (hb <= hr && hb <= tc) begin
      for (int i = 0; i < hb; i++) exp_q.push_back(sb < db ? 2 : 3);
      path_q.push_back(0);
    end else if (hr <= tc) begin
      for (int i = 0; i < hr; i++) exp_q.push_back(sr < dr ? 0 : 1);
      path_q.push_back(1);
    end else begin
      for (int i = 0; i < iabs(sb - tb); i++) exp_q.push_back(sb < tb ? 2 : 3);
      for (int i = 0; i < iabs(tr - dr); i++) exp_q.push_back(tr < dr ? 0 : 1);
      path_q.push_back(2);
    end
    exp_q.push_back(ARRIVE);
  endtask

  task automatic send(int a, int b, int c, int e);
    @(negedge clk);
    while (busy) @(negedge clk);
    expect_route(a, b, c, e);
    sx = 3'(a); sy = 3'(b); dx = 3'(c); dy = 3'(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    while (busy) @(negedge clk);
  endtask

  // monitor: pops and compares beats as they appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (hop_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 extra hop", int'(hop_dir), -1);
        else begin
          int ev;
          ev = exp_q.pop_front();
          chk(int'(hop_dir) == ev, "R2/R7 hop code", int'(hop_dir), ev);
        end
      end
      if (done) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 extra arrival", ARRIVE, -1);
        else begin
          int ev;
          ev = exp_q.pop_front();
          chk(ev == ARRIVE, "R8 arrival position", ARRIVE, ev);
        end
        if (path_q.size() != 0) begin
          int pv;
          pv = path_q.pop_front();
          chk(int'(path) == pv, "R3/R4/R5 path choice", int'(path), pv);
        end
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    chk(1'b0, "watchdog", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(hop_valid == 1'b0, "R1 hop_valid", int'(hop_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(path == 2'd0, "R1 path", int'(path), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(3, 3, 3, 3);  // R8 arrival only
    send(0, 0, 6, 6);  // R5 turn forced
    send(0, 0, 1, 0);  // R4 row neighbour via red
    send(0, 0, 0, 1);  // R3 column neighbour via blue
    send(6, 6, 0, 0);  // R6 turn, decreasing legs
    send(2, 5, 2, 0);  // R3 five-hop column

    // R9: second start while busy must not change the route
    @(negedge clk);
    expect_route(1, 1, 5, 4);
    sx = 3'd1; sy = 3'd1; dx = 3'd5; dy = 3'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    sx = 3'd6; sy = 3'd0; dx = 3'd0; dy = 3'd6;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 ignored start", int'(busy), 0);

    // R2 sweep over every destination from four sources
    for (int s = 0; s < 4; s++) begin
      int ax, ay;
      ax = (s == 0) ? 0 : (s == 1) ? 3 : (s == 2) ? 6 : 2;
      ay = (s == 0) ? 0 : (s == 1) ? 3 : (s == 2) ? 0 : 5;
      for (int t = 0; t < D * D; t++) send(ax, ay, t / D, t % D);
    end

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all beats seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule